// File: doc/BRIEF.md
# Floating-Point Operand Screen and Status Register

This block sits between the issue logic and a single/double-precision floating-point datapath. It looks at up to three operands and works out, without a clock, which are NaNs and which are denormals. Then it applies the denormal policy that a control bit in its own status register selects. In trapping mode (policy bit clear), a denormal operand vetoes the operation. In flushing mode (policy bit set), every denormal is rewritten to a zero with the same sign before the datapath sees it, and the operation goes ahead.

When the datapath reports a result with its valid strobe, the block updates the status register. The five per-operation cause bits are overwritten. The five sticky flags accumulate. A vetoed operation only raises the operand-error cause. A host write port loads the whole register and wins over any update in the same cycle.

A two-state machine follows the rounding-mode field. `RND_NEAREST` goes to `RND_ZERO` when the host writes field value 01. `RND_ZERO` goes back to `RND_NEAREST` when the host writes 00. Any other value keeps the current state. The register update is chosen each cycle by a four-way update kind with a fixed priority: `UPD_HOST` first, then `UPD_ABORT`, then `UPD_COMMIT`, otherwise `UPD_IDLE`.

Status register layout:
- bits 4:0: flags, in the order inexact, underflow, overflow, divide-by-zero, invalid.
- bits 9:5: causes, in the same order.
- bit 10: operand-error cause.
- bits 15:11: enables, in the same order.
- bits 17:16: rounding field.
- bit 18: denormal policy.

The `exc` input uses bit 0 = inexact, bit 1 = underflow, bit 2 = overflow, bit 3 = infinite result (divide-by-zero), bit 4 = invalid.

Top module: `fpu_screen_status`

## Requirements
- R1: An operand is a NaN when its exponent is all ones and its fraction is nonzero. In single precision (`dbl`=0) the exponent is bits 30:23 and the fraction is bits 22:0. In double precision the exponent is bits 62:52 and the fraction is bits 51:0. An infinity (fraction zero) is not a NaN.
- R2: An operand is denormal when its exponent is all zeros and its fraction is nonzero, using the same fields as R1.
- R3: With policy bit 18 clear and `opnd_cnt` of 2 or 3, `abort` is high with `res_valid`, and `proceed` is low, exactly when none of the counted operands is a NaN and at least one of them is denormal. Operands beyond the count are ignored.
- R4: With policy bit 18 clear and `opnd_cnt` of 0 or 1, only `op_a` is examined. A denormal `op_a` vetoes the operation, and `op_b` and `op_c` have no effect.
- R5: With policy bit 18 set, `abort` never rises. Each denormal operand is output as a signed zero: in single precision bits 30:0 are cleared and bits 63:31 are kept; in double precision bits 62:0 are cleared. Other operands, and all operands with the bit clear, pass unchanged.
- R6: On a `res_valid` edge that is not vetoed and has no host write, status bits 9:5 take the value of `exc`.
- R7: On such an edge, status bits 4:0 become their old value OR `exc`. No operation clears a flag.
- R8: A host write with rounding field 00 selects round-to-nearest (`rnd_toward_zero`=0). A write with 01 selects toward-zero (`rnd_toward_zero`=1). A write with 10 or 11 keeps the previous selection.
- R9: On a `host_we` edge the status register takes `host_wdata`, whatever `res_valid` does in that cycle.
- R10: After reset the status register is 0 and `rnd_toward_zero` is 0.
- R11: A vetoed `res_valid` edge sets bit 10 and leaves every other status bit unchanged. Bit 10 is cleared only by a host write. With neither `res_valid` nor `host_we`, the status register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 64 | First operand (single precision in bits 31:0) |
| op_b | input | 64 | Second operand |
| op_c | input | 64 | Third operand |
| dbl | input | 1 | 1 = double precision |
| opnd_cnt | input | 2 | Number of operands examined (0 and 1 both mean one) |
| exc | input | 5 | Raw exception indications from the datapath |
| res_valid | input | 1 | Datapath result strobe |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 19 | Host write data for the status register |
| op_a_out | output | 64 | Screened first operand |
| op_b_out | output | 64 | Screened second operand |
| op_c_out | output | 64 | Screened third operand |
| proceed | output | 1 | Operation is allowed |
| abort | output | 1 | Veto pulse, high with `res_valid` when the operation is suppressed |
| status | output | 19 | Status register |
| rnd_toward_zero | output | 1 | Decoded rounding mode |

## Verification
The screened operands, `proceed` and `abort` are combinational, so they are due in the same cycle as the stimulus. The bench samples them 1 ns after driving the inputs and before the next rising edge. The status register and the rounding mode pass through one register each, so they are due after the first rising edge following the stimulus. The bench compares them 1 ns after that edge with a behavioural model that it advanced with the values present before the edge. This comparison is made on every clock.

// File: rtl/fss_pkg.sv
package fss_pkg;
    localparam int EXC_W     = 5;
    localparam int FLAG_LSB  = 0;
    localparam int CAUSE_LSB = 5;
    localparam int ERR_BIT   = 10;
    localparam int EN_LSB    = 11;
    localparam int RM_LSB    = 16;
    localparam int DN_BIT    = 18;
    localparam int STAT_W    = 19;

    typedef enum logic [0:0] {
        RND_NEAREST = 1'b0,
        RND_ZERO    = 1'b1
    } rnd_state_e;

    typedef enum logic [1:0] {
        UPD_IDLE,
        UPD_HOST,
        UPD_ABORT,
        UPD_COMMIT
    } upd_kind_e;
endpackage

// File: rtl/fss_classify.sv
module fss_classify #(
    parameter int SP_EXP  = 8,
    parameter int SP_FRAC = 23,
    parameter int DP_EXP  = 11,
    parameter int DP_FRAC = 52
) (
    input  logic [DP_EXP+DP_FRAC:0] opnd,
    input  logic                    dbl,
    input  logic                    flush_en,
    output logic                    is_nan,
    output logic                    is_den,
    output logic [DP_EXP+DP_FRAC:0] opnd_out
);
    localparam int SP_SIGN = SP_EXP + SP_FRAC;
    localparam int DP_SIGN = DP_EXP + DP_FRAC;

    logic [SP_EXP-1:0]  sp_exp;
    logic [SP_FRAC-1:0] sp_frac;
    logic [DP_EXP-1:0]  dp_exp;
    logic [DP_FRAC-1:0] dp_frac;
    logic sp_nan, sp_den, dp_nan, dp_den;

    always_comb begin
        sp_exp  = opnd[SP_SIGN-1:SP_FRAC];
        sp_frac = opnd[SP_FRAC-1:0];
        dp_exp  = opnd[DP_SIGN-1:DP_FRAC];
        dp_frac = opnd[DP_FRAC-1:0];
        sp_nan  = (&sp_exp) && (|sp_frac);
        sp_den  = (~|sp_exp) && (|sp_frac);
        dp_nan  = (&dp_exp) && (|dp_frac);
        dp_den  = (~|dp_exp) && (|dp_frac);
        is_nan  = dbl ? dp_nan : sp_nan;
        is_den  = dbl ? dp_den : sp_den;
    end

    always_comb begin
        opnd_out = opnd;
        if (flush_en && is_den) begin
            if (dbl) begin
                opnd_out          = '0;
                opnd_out[DP_SIGN] = opnd[DP_SIGN];
            end else begin
                opnd_out[SP_SIGN-1:0] = '0;
            end
        end
    end
endmodule

// File: rtl/fss_screen.sv
module fss_screen #(
    parameter int NUM_OPS = 3,
    parameter int SP_EXP  = 8,
    parameter int SP_FRAC = 23,
    parameter int DP_EXP  = 11,
    parameter int DP_FRAC = 52,
    localparam int DATA_W = 1 + DP_EXP + DP_FRAC,
    localparam int CNT_W  = $clog2(NUM_OPS + 1)
) (
    input  logic [NUM_OPS-1:0][DATA_W-1:0] ops_i,
    input  logic                           dbl,
    input  logic                           dn,
    input  logic [CNT_W-1:0]               cnt,
    output logic [NUM_OPS-1:0][DATA_W-1:0] ops_o,
    output logic                           suppress
);
    logic [NUM_OPS-1:0] nan_v, den_v, active;
    logic any_nan, any_den;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        fss_classify #(
            .SP_EXP (SP_EXP),
            .SP_FRAC(SP_FRAC),
            .DP_EXP (DP_EXP),
            .DP_FRAC(DP_FRAC)
        ) u_cls (
            .opnd    (ops_i[i]),
            .dbl     (dbl),
            .flush_en(dn),
            .is_nan  (nan_v[i]),
            .is_den  (den_v[i]),
            .opnd_out(ops_o[i])
        );
        if (i == 0) begin : g_first
            assign active[i] = 1'b1;
        end else begin : g_rest
            assign active[i] = (CNT_W'(i) < cnt);
        end
    end

    always_comb begin
        any_nan = |(nan_v & active);
        any_den = |(den_v & active);
        if (dn)
            suppress = 1'b0;
        else if (cnt <= CNT_W'(1))
            suppress = den_v[0];
        else
            suppress = any_den && !any_nan;
    end
endmodule

// File: rtl/fss_status.sv
module fss_status
    import fss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic              suppress,
    input  logic [EXC_W-1:0]  exc,
    input  logic              host_we,
    input  logic [STAT_W-1:0] host_wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic              rnd_zero
);
    upd_kind_e  kind;
    rnd_state_e rnd_q, rnd_next;

    always_comb begin
        if (host_we)
            kind = UPD_HOST;
        else if (res_valid && suppress)
            kind = UPD_ABORT;
        else if (res_valid)
            kind = UPD_COMMIT;
        else
            kind = UPD_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            unique case (kind)
                UPD_HOST:  stat_q <= host_wdata;
                UPD_ABORT: stat_q[ERR_BIT] <= 1'b1;
                UPD_COMMIT: begin
                    stat_q[CAUSE_LSB +: EXC_W] <= exc;
                    stat_q[FLAG_LSB +: EXC_W]  <= stat_q[FLAG_LSB +: EXC_W] | exc;
                end
                UPD_IDLE:  stat_q <= stat_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rnd_q <= RND_NEAREST;
        else        rnd_q <= rnd_next;
    end

    always_comb begin
        rnd_next = rnd_q;
        if (kind == UPD_HOST) begin
            unique case (host_wdata[RM_LSB +: 2])
                2'b00:   rnd_next = RND_NEAREST;
                2'b01:   rnd_next = RND_ZERO;
                default: rnd_next = rnd_q;
            endcase
        end
    end

    assign rnd_zero = (rnd_q == RND_ZERO);

    // R7
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> ((stat_q[FLAG_LSB +: EXC_W] & $past(stat_q[FLAG_LSB +: EXC_W]))
                      == $past(stat_q[FLAG_LSB +: EXC_W])));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we && !res_valid) |=> $stable(stat_q));
    // R8
    rm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_wdata[RM_LSB+1]) |=> $stable(rnd_q));
    // R9
    host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> (stat_q == $past(host_wdata)));
    // R6
    cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !suppress && !host_we) |=> (stat_q[CAUSE_LSB +: EXC_W] == $past(exc)));
endmodule

// File: rtl/fpu_screen_status.sv
module fpu_screen_status
    import fss_pkg::*;
#(
    parameter int SP_EXP  = 8,
    parameter int SP_FRAC = 23,
    parameter int DP_EXP  = 11,
    parameter int DP_FRAC = 52,
    localparam int DATA_W = 1 + DP_EXP + DP_FRAC,
    localparam int NUM_OPS = 3,
    localparam int CNT_W  = $clog2(NUM_OPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    input  logic              dbl,
    input  logic [CNT_W-1:0]  opnd_cnt,
    input  logic [EXC_W-1:0]  exc,
    input  logic              res_valid,
    input  logic              host_we,
    input  logic [STAT_W-1:0] host_wdata,
    output logic [DATA_W-1:0] op_a_out,
    output logic [DATA_W-1:0] op_b_out,
    output logic [DATA_W-1:0] op_c_out,
    output logic              proceed,
    output logic              abort,
    output logic [STAT_W-1:0] status,
    output logic              rnd_toward_zero
);
    logic [NUM_OPS-1:0][DATA_W-1:0] ops_in, ops_scr;
    logic suppress;

    assign ops_in = {op_c, op_b, op_a};

    fss_screen #(
        .NUM_OPS(NUM_OPS),
        .SP_EXP (SP_EXP),
        .SP_FRAC(SP_FRAC),
        .DP_EXP (DP_EXP),
        .DP_FRAC(DP_FRAC)
    ) u_screen (
        .ops_i   (ops_in),
        .dbl     (dbl),
        .dn      (status[DN_BIT]),
        .cnt     (opnd_cnt),
        .ops_o   (ops_scr),
        .suppress(suppress)
    );

    fss_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .suppress  (suppress),
        .exc       (exc),
        .host_we   (host_we),
        .host_wdata(host_wdata),
        .stat_q    (status),
        .rnd_zero  (rnd_toward_zero)
    );

    assign op_a_out = ops_scr[0];
    assign op_b_out = ops_scr[1];
    assign op_c_out = ops_scr[2];
    assign proceed  = !suppress;
    assign abort    = res_valid && suppress;

    // R11
    abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !host_we) |=> (status[ERR_BIT] &&
            (status[ERR_BIT-1:0] == $past(status[ERR_BIT-1:0]))));
    // R5
    flush_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[DN_BIT] |-> (proceed && !abort));
endmodule

// File: tb/sim_fpu_screen_status.sv
module sim_fpu_screen_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0, op_b = '0, op_c = '0;
    logic        dbl = 1'b0;
    logic [1:0]  opnd_cnt = 2'd2;
    logic [4:0]  exc = '0;
    logic        res_valid = 1'b0, host_we = 1'b0;
    logic [18:0] host_wdata = '0;
    logic [63:0] op_a_out, op_b_out, op_c_out;
    logic        proceed, abort, rnd_toward_zero;
    logic [18:0] status;

    int n_run = 0, n_fail = 0;
    logic [18:0] m_stat = '0;
    bit          m_rz = 1'b0;

    always #2 clk = ~clk;

    fpu_screen_status u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .dbl(dbl), .opnd_cnt(opnd_cnt), .exc(exc), .res_valid(res_valid),
        .host_we(host_we), .host_wdata(host_wdata),
        .op_a_out(op_a_out), .op_b_out(op_b_out), .op_c_out(op_c_out),
        .proceed(proceed), .abort(abort), .status(status),
        .rnd_toward_zero(rnd_toward_zero)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // R1 R2 behavioural field tests
    function automatic bit m_nan(logic [63:0] x, bit d);
        logic [63:0] e, f;
        if (d) begin e = (x >> 52) & 64'h7ff; f = x % (64'd1 << 52); return (e == 64'h7ff) && (f != 0); end
        e = (x >> 23) & 64'hff; f = x % (64'd1 << 23);
        return (e == 64'hff) && (f != 0);
    endfunction

    function automatic bit m_den(logic [63:0] x, bit d);
        logic [63:0] e, f;
        if (d) begin e = (x >> 52) & 64'h7ff; f = x % (64'd1 << 52); return (e == 0) && (f != 0); end
        e = (x >> 23) & 64'hff; f = x % (64'd1 << 23);
        return (e == 0) && (f != 0);
    endfunction

    function automatic logic [63:0] m_flush(logic [63:0] x, bit d, bit dn);
        if (!dn || !m_den(x, d)) return x;
        return d ? (x & 64'h8000_0000_0000_0000) : (x & 64'hFFFF_FFFF_8000_0000);
    endfunction

    task automatic cycle();
        logic [63:0] ops [3];
        bit sup, anyn, anyd, dn;
        int n;
        logic [18:0] nx;
        bit nrz;
        ops[0] = op_a; ops[1] = op_b; ops[2] = op_c;
        #1;
        dn = m_stat[18];
        n = (opnd_cnt < 2) ? 1 : int'(opnd_cnt);
        anyn = 0; anyd = 0;
        for (int i = 0; i < n; i++) begin
            anyn |= m_nan(ops[i], dbl);
            anyd |= m_den(ops[i], dbl);
        end
        sup = !dn && (n == 1 ? m_den(ops[0], dbl) : (anyd && !anyn));
        chk(abort == (res_valid && sup), "R1 R2 R3 R4 abort", 64'(abort), 64'(res_valid && sup));
        chk(proceed == !sup, "R3 R4 R5 proceed", 64'(proceed), 64'(!sup));
        chk(op_a_out == m_flush(op_a, dbl, dn), "R5 op_a_out", op_a_out, m_flush(op_a, dbl, dn));
        chk(op_b_out == m_flush(op_b, dbl, dn), "R5 op_b_out", op_b_out, m_flush(op_b, dbl, dn));
        chk(op_c_out == m_flush(op_c, dbl, dn), "R5 op_c_out", op_c_out, m_flush(op_c, dbl, dn));
        nx = m_stat; nrz = m_rz;
        if (host_we) begin
            nx = host_wdata;
            if (host_wdata[17:16] == 2'b00) nrz = 0;
            else if (host_wdata[17:16] == 2'b01) nrz = 1;
        end else if (res_valid) begin
            if (sup) nx[10] = 1'b1;
            else begin
                nx[9:5] = exc;
                nx[4:0] = m_stat[4:0] | exc;
            end
        end
        @(posedge clk);
        m_stat = nx; m_rz = nrz;
        #1;
        chk(status == m_stat, "R6 R7 R9 R11 status", 64'(status), 64'(m_stat));
        chk(rnd_toward_zero == m_rz, "R8 rounding", 64'(rnd_toward_zero), 64'(m_rz));
        @(negedge clk);
    endtask

    task automatic drv(input logic [63:0] a, b, c, input bit d, input logic [1:0] cn,
                       input logic [4:0] e, input bit v, input bit we, input logic [18:0] wd);
        op_a = a; op_b = b; op_c = c; dbl = d; opnd_cnt = cn;
        exc = e; res_valid = v; host_we = we; host_wdata = wd;
        cycle();
    endtask

    localparam logic [63:0] SP_ONE  = 64'h3F80_0000;
    localparam logic [63:0] SP_DEN  = 64'h0000_0001;
    localparam logic [63:0] SP_NAN  = 64'h7FC0_0000;
    localparam logic [63:0] SP_INF  = 64'h7F80_0000;
    localparam logic [63:0] DP_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] DP_DEN  = 64'h000F_0000_0000_0000;
    localparam logic [63:0] DP_NAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] DP_INF  = 64'h7FF0_0000_0000_0000;

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(status == 19'd0, "R10 reset status", 64'(status), 64'd0);
        chk(rnd_toward_zero == 1'b0, "R10 reset rounding", 64'(rnd_toward_zero), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 enables on, trapping policy
        drv(SP_ONE, SP_ONE, 0, 0, 2, 0, 0, 1, 19'h0F800);
        // R6 R7 commits
        drv(SP_ONE, SP_ONE, 0, 0, 2, 5'b00001, 1, 0, 0);
        drv(SP_ONE, SP_ONE, 0, 0, 2, 5'b01000, 1, 0, 0);
        drv(SP_ONE, SP_ONE, 0, 0, 2, 5'b10110, 1, 0, 0);
        // R11 idle hold with noisy exc
        drv(SP_DEN, SP_ONE, 0, 0, 2, 5'b11111, 0, 0, 0);
        // R3 denormal veto, NaN overrides
        drv(SP_DEN, SP_ONE, 0, 0, 2, 5'b00011, 1, 0, 0);
        drv(SP_DEN, SP_NAN, 0, 0, 2, 5'b00000, 1, 0, 0);
        drv(SP_INF, SP_DEN, 0, 0, 2, 5'b00100, 1, 0, 0);
        // R4 single operand
        drv(SP_DEN, SP_NAN, 0, 0, 1, 5'b00001, 1, 0, 0);
        drv(SP_ONE, SP_DEN, SP_DEN, 0, 1, 5'b00010, 1, 0, 0);
        drv(SP_DEN, SP_NAN, 0, 0, 0, 5'b00001, 1, 0, 0);
        // R3 third operand counted or not
        drv(SP_ONE, SP_ONE, SP_DEN, 0, 3, 5'b00001, 1, 0, 0);
        drv(SP_ONE, SP_ONE, SP_DEN, 0, 2, 5'b01000, 1, 0, 0);
        drv(SP_NAN, SP_ONE, SP_DEN, 0, 3, 5'b10000, 1, 0, 0);
        // R1 R2 double precision fields
        drv(DP_INF, DP_DEN, 0, 1, 2, 5'b00001, 1, 0, 0);
        drv(DP_NAN, DP_DEN, 0, 1, 2, 5'b10000, 1, 0, 0);
        drv(DP_ONE, SP_DEN, 0, 1, 2, 5'b00001, 1, 0, 0);
        drv(DP_ONE, SP_ONE, 0, 1, 2, 5'b00100, 1, 0, 0);
        // R8 rounding state machine
        drv(SP_ONE, SP_ONE, 0, 0, 2, 0, 0, 1, 19'h1F800);
        drv(SP_ONE, SP_ONE, 0, 0, 2, 0, 0, 1, 19'h2F800);
        drv(SP_ONE, SP_ONE, 0, 0, 2, 0, 0, 1, 19'h0F800);
        drv(SP_ONE, SP_ONE, 0, 0, 2, 0, 0, 1, 19'h3F800);
        drv(SP_ONE, SP_ONE, 0, 0, 2, 0, 0, 1, 19'h1F800);
        drv(SP_ONE, SP_ONE, 0, 0, 2, 0, 0, 1, 19'h3F800);
        // R9 host write collides with commit and with veto
        drv(SP_ONE, SP_ONE, 0, 0, 2, 5'b11111, 1, 1, 19'h00421);
        drv(SP_DEN, SP_ONE, 0, 0, 2, 5'b00000, 1, 1, 19'h00000);
        // R5 flushing policy
        drv(SP_ONE, SP_ONE, 0, 0, 2, 0, 0, 1, 19'h40000);
        drv(64'hDEAD_BEEF_8040_0000, SP_DEN, SP_NAN, 0, 3, 5'b00001, 1, 0, 0);
        drv(64'h8000_0000_0000_0001, DP_DEN, DP_ONE, 1, 3, 5'b00010, 1, 0, 0);
        drv(SP_DEN, SP_ONE, 0, 0, 1, 5'b00100, 1, 0, 0);
        drv(DP_NAN, DP_INF, 64'h0000_0000_0000_0003, 1, 2, 5'b00000, 1, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule